// File: doc/BRIEF.md
# AAL5 Transmit Cell Segmenter

This block sits between a transmit DMA engine and a cell header builder. It takes packet bytes one per cycle, as a single stream with start and end markers, even when the packet was gathered from several host buffers. It cuts that stream into 48-byte cell payloads and marks the last byte of every cell and the last byte of every packet.

A per-packet flag, sampled with the first byte, selects one of two modes. In AAL5 mode the block appends zero padding and an 8-byte trailer after the data. The trailer holds a user byte, a control byte, the 16-bit packet length and a CRC-32, and brings the packet to a whole number of cells. While padding and trailer bytes go out, the block holds off its input. In pass-through mode the host has already split the data into 48-byte cells, and the bytes go out unchanged with only the boundary markers added. The user byte and control byte come from the descriptor alongside the first byte.

Top module: `sar_tx_aal5_seg`

## Requirements
- R1: After reset `out_valid`, `out_cell_end` and `out_pkt_end` are low and `in_ready` is high.
- R2: An AAL5 packet of N data bytes produces exactly 48*ceil((N+8)/48) output bytes, with `out_cell_end` high on every 48th byte and on no other byte.
- R3: The pad bytes between the last data byte and the trailer are 0x00, and there are (40 - N mod 48) mod 48 of them.
- R4: The first four trailer bytes are the user byte and the control byte (both taken from `in_uu` and `in_cpi` on the byte flagged `in_sop`), then N as a 16-bit value, high byte first. Values on these inputs on other bytes have no effect.
- R5: The last four trailer bytes are the bitwise complement of a CRC-32 sent most significant byte first. The CRC uses polynomial 0x04C11DB7, starts at all ones, takes each byte most significant bit first without reflection, and covers data, pad and the first four trailer bytes.
- R6: `out_pkt_end` is high only on the final byte of a packet: the 48th byte of the last cell in AAL5 mode, or the byte that carried `in_eop` in pass-through mode.
- R7: When `in_aal5` is 0 on the `in_sop` byte, every accepted byte appears unchanged on `out_data`, with no pad or trailer. `out_cell_end` is high on every 48th byte and on the final byte.
- R8: After accepting the `in_eop` byte of an AAL5 packet, `in_ready` stays low for exactly pad+8 cycles, and input offered during that time is not consumed. After a pass-through packet, `in_ready` stays high.
- R9: Idle cycles (`in_valid` low) inside a packet, such as at buffer boundaries, do not change the output bytes or the CRC.
- R10: A byte accepted at a clock edge appears on `out_data` with `out_valid` high right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_aal5 | input | 1 | Packet mode on the first byte: 1 = AAL5, 0 = pre-formatted |
| in_uu | input | 8 | Trailer user byte, sampled with the first byte |
| in_cpi | input | 8 | Trailer control byte, sampled with the first byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Cell payload byte |
| out_cell_end | output | 1 | Last byte of a cell |
| out_pkt_end | output | 1 | Last byte of the packet's final cell |

## Verification
A corrupted cell-position counter shows up at the ports as an `out_cell_end` that slips away from every 48th byte, and it does so within the cell where the error happens. The same fault also changes the pad count, so the trailer lands in the wrong place and `out_pkt_end` moves. A wrong CRC or length state stays hidden until the last eight bytes of the packet. Because of that, the bench drives packet lengths on both sides of the 40-byte boundary and inserts idle gaps inside packets. A sequencer that leaves its fill phase one cycle early or late shows up right away as a wrong `in_ready` stall count after the end-of-packet byte.

// File: rtl/sar_tx_pkg.sv
package sar_tx_pkg;

  typedef enum logic [1:0] {
    ST_DATA  = 2'd0,
    ST_PAD   = 2'd1,
    ST_TRAIL = 2'd2
  } seg_state_e;

  localparam int unsigned TRL_BYTES = 8;
  localparam int unsigned LEN_W     = 16;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

  // One byte of a non-reflected CRC-32, MSB of the byte first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fb = r[31] ^ d[k];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/sar_tx_crc.sv
module sar_tx_crc
  import sar_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        restart,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);

  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (en) crc_d = crc32_byte(restart ? CRC_SEED : crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= CRC_SEED;
    else if (en) crc_q <= crc_d;
  end

endmodule

// File: rtl/sar_tx_seq.sv
module sar_tx_seq
  import sar_tx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 48
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_sop,
  input  logic                          in_eop,
  input  logic                          in_aal5,
  output logic                          in_ready,
  output logic                          emit,
  output logic                          cell_end,
  output logic                          pkt_end,
  output logic                          pkt_aal5,
  output seg_state_e                    state_q,
  output logic [$clog2(CELL_BYTES)-1:0] pos_q,
  output logic [LEN_W-1:0]              len_q
);

  localparam int unsigned POS_W = $clog2(CELL_BYTES);
  localparam int unsigned BODY  = CELL_BYTES - TRL_BYTES;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CELL_BYTES - 1);
  localparam logic [POS_W-1:0] POS_BODY = POS_W'(BODY);

  seg_state_e       state_d;
  logic [POS_W-1:0] pos_d, pos_inc;
  logic [LEN_W-1:0] len_d;
  logic             aal5_q, aal5_d;

  assign pos_inc  = (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);
  assign pkt_aal5 = in_sop ? in_aal5 : aal5_q;

  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    len_d    = len_q;
    aal5_d   = aal5_q;
    in_ready = 1'b0;
    emit     = 1'b0;
    cell_end = 1'b0;
    pkt_end  = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        in_ready = 1'b1;
        if (in_valid) begin
          emit   = 1'b1;
          aal5_d = pkt_aal5;
          len_d  = in_sop ? LEN_W'(1) : len_q + LEN_W'(1);
          if (in_eop && !pkt_aal5) begin
            pos_d    = '0;
            cell_end = 1'b1;
            pkt_end  = 1'b1;
          end else begin
            pos_d    = pos_inc;
            cell_end = (pos_q == POS_LAST);
            if (in_eop) state_d = (pos_inc == POS_BODY) ? ST_TRAIL : ST_PAD;
          end
        end
      end
      ST_PAD: begin
        emit     = 1'b1;
        pos_d    = pos_inc;
        cell_end = (pos_q == POS_LAST);
        if (pos_inc == POS_BODY) state_d = ST_TRAIL;
      end
      ST_TRAIL: begin
        emit     = 1'b1;
        cell_end = (pos_q == POS_LAST);
        if (pos_q == POS_LAST) begin
          pkt_end = 1'b1;
          pos_d   = '0;
          state_d = ST_DATA;
        end else begin
          pos_d = pos_q + POS_W'(1);
        end
      end
      default: state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DATA;
      pos_q   <= '0;
      len_q   <= '0;
      aal5_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
      aal5_q  <= aal5_d;
    end
  end

  // R2: the cell position never leaves the cell
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST);

  // R4: trailer bytes only occupy the final eight slots of a cell
  p_trail_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIL) |-> (pos_q >= POS_BODY));

  // R3: padding is always followed by more padding or by the trailer
  p_pad_to_trail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |=> (state_q == ST_PAD || state_q == ST_TRAIL));

  // R6: the closing trailer byte returns the sequencer to cell start
  p_trail_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIL && pos_q == POS_LAST) |=> (state_q == ST_DATA && pos_q == '0));

endmodule

// File: rtl/sar_tx_aal5_seg.sv
module sar_tx_aal5_seg
  import sar_tx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       in_aal5,
  input  logic [7:0] in_uu,
  input  logic [7:0] in_cpi,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_cell_end,
  output logic       out_pkt_end
);

  localparam int unsigned POS_W = $clog2(CELL_BYTES);
  localparam int unsigned BODY  = CELL_BYTES - TRL_BYTES;

  seg_state_e       state_q;
  logic [POS_W-1:0] pos_q;
  logic [LEN_W-1:0] len_q;
  logic             emit, cell_end, pkt_end, pkt_aal5;
  logic [2:0]       tidx;
  logic [7:0]       byte_mux, uu_q, cpi_q;
  logic [31:0]      crc_q;
  logic             crc_en, crc_restart, fld_en;

  sar_tx_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_aal5  (in_aal5),
    .in_ready (in_ready),
    .emit     (emit),
    .cell_end (cell_end),
    .pkt_end  (pkt_end),
    .pkt_aal5 (pkt_aal5),
    .state_q  (state_q),
    .pos_q    (pos_q),
    .len_q    (len_q)
  );

  // Trailer control fields, captured with the first byte of the packet
  assign fld_en = in_valid && in_ready && in_sop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uu_q  <= '0;
      cpi_q <= '0;
    end else if (fld_en) begin
      uu_q  <= in_uu;
      cpi_q <= in_cpi;
    end
  end

  assign tidx = 3'(pos_q - POS_W'(BODY));

  always_comb begin
    byte_mux = 8'h00;
    unique case (state_q)
      ST_DATA:  byte_mux = in_data;
      ST_PAD:   byte_mux = 8'h00;
      ST_TRAIL: begin
        unique case (tidx)
          3'd0:    byte_mux = uu_q;
          3'd1:    byte_mux = cpi_q;
          3'd2:    byte_mux = len_q[15:8];
          3'd3:    byte_mux = len_q[7:0];
          3'd4:    byte_mux = ~crc_q[31:24];
          3'd5:    byte_mux = ~crc_q[23:16];
          3'd6:    byte_mux = ~crc_q[15:8];
          default: byte_mux = ~crc_q[7:0];
        endcase
      end
      default:  byte_mux = 8'h00;
    endcase
  end

  always_comb begin
    crc_en = 1'b0;
    unique case (state_q)
      ST_DATA:  crc_en = emit && pkt_aal5;
      ST_PAD:   crc_en = 1'b1;
      ST_TRAIL: crc_en = (tidx < 3'd4);
      default:  crc_en = 1'b0;
    endcase
  end

  assign crc_restart = (state_q == ST_DATA) && in_sop;

  sar_tx_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (crc_en),
    .restart (crc_restart),
    .data    (byte_mux),
    .crc_q   (crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_cell_end <= 1'b0;
      out_pkt_end  <= 1'b0;
    end else begin
      out_valid    <= emit;
      out_cell_end <= cell_end;
      out_pkt_end  <= pkt_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_data <= '0;
    else if (emit) out_data <= byte_mux;
  end

  // R6: a packet end is always also a cell end on a valid byte
  p_pkt_end_on_cell_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_pkt_end |-> (out_cell_end && out_valid));

  // R8: while input is held off, the byte count does not move
  p_stall_holds_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(len_q));

  // R7 / R10: an accepted byte shows up one edge later on the output
  p_accept_to_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: tb/test_sar_tx_aal5_seg.sv
module test_sar_tx_aal5_seg;

  localparam int CLK_PERIOD = 10;
  localparam int CELL = 48;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sop, in_eop, in_aal5;
  logic [7:0] in_data, in_uu, in_cpi;
  logic       out_valid, out_cell_end, out_pkt_end;
  logic [7:0] out_data;

  int n_checks = 0;
  int n_errs   = 0;
  logic [12:0] exp_q[$];   // {kind[2:0], pkt_end, cell_end, data[7:0]}

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_tx_aal5_seg #(.CELL_BYTES(CELL)) i_sar_tx_aal5_seg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_aal5(in_aal5),
    .in_uu(in_uu), .in_cpi(in_cpi),
    .out_valid(out_valid), .out_data(out_data),
    .out_cell_end(out_cell_end), .out_pkt_end(out_pkt_end)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    bit fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fb = r[31] ^ d[k];
      r  = r << 1;
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] kind);
    case (kind)
      3'd0: return "R7";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5 R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // Output monitor: compares every emitted byte with the model queue
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected byte", {24'h0, out_data}, 32'h0);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk(out_data === e[7:0], req_of(e[12:10]), {24'h0, out_data}, {24'h0, e[7:0]});
        chk(out_cell_end === e[8], "R2 cell end", {31'h0, out_cell_end}, {31'h0, e[8]});
        chk(out_pkt_end === e[9], "R6 packet end", {31'h0, out_pkt_end}, {31'h0, e[9]});
      end
    end
  end

  task automatic push_exp(input logic [2:0] kind, input bit pe, input bit ce, input logic [7:0] d);
    exp_q.push_back({kind, pe, ce, d});
  endtask

  task automatic send_pkt(input int n, input bit aal5, input bit gaps, input bit lat_chk);
    logic [7:0] pkt[$];
    logic [7:0] uu, cpi;
    logic [31:0] c;
    int pos, pad, stall;
    uu  = 8'($urandom);
    cpi = 8'($urandom);
    for (int i = 0; i < n; i++) pkt.push_back(8'($urandom));
    // model
    c = 32'hFFFF_FFFF;
    pos = 0;
    for (int i = 0; i < n; i++) begin
      if (aal5) c = ref_crc(c, pkt[i]);
      push_exp(aal5 ? 3'd1 : 3'd0, !aal5 && i == n-1, (pos == CELL-1) || (!aal5 && i == n-1), pkt[i]);
      pos = (pos + 1) % CELL;
    end
    pad = aal5 ? (40 - (n % CELL) + CELL) % CELL : 0;
    if (aal5) begin
      logic [7:0] tr[4];
      for (int i = 0; i < pad; i++) begin
        c = ref_crc(c, 8'h00);
        push_exp(3'd2, 1'b0, pos == CELL-1, 8'h00);
        pos = (pos + 1) % CELL;
      end
      tr[0] = uu; tr[1] = cpi; tr[2] = 8'(n >> 8); tr[3] = 8'(n);
      for (int i = 0; i < 4; i++) begin
        c = ref_crc(c, tr[i]);
        push_exp(3'd3, 1'b0, 1'b0, tr[i]);
      end
      c = ~c;
      for (int i = 0; i < 4; i++)
        push_exp(3'd4, i == 3, i == 3, 8'(c >> (24 - 8*i)));
    end
    // drive
    for (int i = 0; i < n; i++) begin
      if (gaps && $urandom_range(3) == 0) begin  // R9: idle cycle between buffers
        in_valid = 1'b0;
        @(negedge clk);
      end
      if (lat_chk && i == 1)  // R10: first byte visible right after its edge
        chk(out_valid === 1'b1 && out_data === pkt[0], "R10 latency", {23'h0, out_valid, out_data}, {23'h0, 1'b1, pkt[0]});
      in_valid = 1'b1;
      in_data  = pkt[i];
      in_sop   = (i == 0);
      in_eop   = (i == n-1);
      in_aal5  = (i == 0) ? aal5 : 1'($urandom);
      in_uu    = (i == 0) ? uu  : 8'($urandom);
      in_cpi   = (i == 0) ? cpi : 8'($urandom);
      @(negedge clk);
    end
    // R8: count stall cycles while offering garbage that must not be taken
    stall = 0;
    while (in_ready !== 1'b1) begin
      in_valid = 1'b1;
      in_data  = 8'($urandom);
      in_sop   = 1'($urandom);
      in_eop   = 1'($urandom);
      in_aal5  = 1'($urandom);
      stall++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    chk(stall == (aal5 ? pad + 8 : 0), "R8 stall cycles", 32'(stall), 32'(aal5 ? pad + 8 : 0));
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    int wait_cyc;
    void'($urandom(32'd20260));
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
    in_aal5 = 1'b0; in_uu = '0; in_cpi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(out_valid === 1'b0, "R1 out_valid", {31'h0, out_valid}, 32'h0);
    chk(out_cell_end === 1'b0 && out_pkt_end === 1'b0, "R1 flags", {30'h0, out_cell_end, out_pkt_end}, 32'h0);
    chk(in_ready === 1'b1, "R1 in_ready", {31'h0, in_ready}, 32'h1);

    // directed: pass-through and the pad boundaries
    send_pkt(48, 1'b0, 1'b0, 1'b1);   // R7, R10
    send_pkt(2, 1'b1, 1'b0, 1'b1);    // R10 in AAL5 mode
    send_pkt(1, 1'b1, 1'b0, 1'b0);    // R3: pad 39
    send_pkt(39, 1'b1, 1'b0, 1'b0);   // R3: pad 1
    send_pkt(40, 1'b1, 1'b0, 1'b0);   // R3: no pad
    send_pkt(41, 1'b1, 1'b0, 1'b0);   // R3: pad 47, two cells
    send_pkt(47, 1'b1, 1'b0, 1'b0);
    send_pkt(48, 1'b1, 1'b0, 1'b0);   // R3: pad 40
    send_pkt(88, 1'b1, 1'b1, 1'b0);   // R9 with gaps
    send_pkt(96, 1'b0, 1'b1, 1'b0);   // R7 with gaps
    send_pkt(300, 1'b1, 1'b1, 1'b0);  // R4: length above 255

    // random mix
    for (int p = 0; p < 40; p++) begin
      bit a;
      a = 1'($urandom);
      if (a) send_pkt(1 + $urandom_range(199), 1'b1, 1'($urandom), 1'b0);
      else   send_pkt(48 * (1 + $urandom_range(2)), 1'b0, 1'($urandom), 1'b0);
    end

    wait_cyc = 0;
    while (exp_q.size() != 0 && wait_cyc < 200) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk(exp_q.size() == 0, "R2 all bytes emitted", 32'(exp_q.size()), 32'h0);
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R8 idle at end", {30'h0, out_valid, in_ready}, 32'h1);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule